// File: doc/BRIEF.md
# Linked DMA Descriptor Queue Manager

This block keeps one queue of packet descriptors in a small on-chip descriptor RAM. Each RAM entry holds a status word, a control word, a data size, a total length, a last-descriptor index and a next-descriptor index. The queue is a chain that starts at a head pointer and ends at a fixed terminator descriptor. There is no null link. A packet can span several descriptors. The packet is removed as one unit: the next packet starts at the next-link of the descriptor that the head's last-descriptor field names.

A controller issues one command at a time through a valid/ready handshake. The commands are:

- write and read a whole descriptor;
- dequeue the head packet when its 2-bit ownership code matches a requested value, or when it differs from it;
- append an already linked chain;
- re-arm a descriptor to hardware ownership;
- restore a receive descriptor to its idle form;
- count the descriptors in the queue.

Each command ends with a one-cycle response pulse that carries its result. Links are stored as RAM indices, not byte addresses. Data buffers and bus transfers are outside this block.

Top module: `dq_queue_mgr`

## Requirements
- R1: After synchronous reset the queue is empty (`q_empty`=1), `cmd_ready`=1 and `rsp_valid`=0.
- R2: A write command (op 0) stores all six fields of `cmd_idx`. A read command (op 1) returns them on `rsp_status`, `rsp_ctrl`, `rsp_dsize`, `rsp_tlen`, `rsp_last` and `rsp_next`.
- R3: A match-dequeue (op 2) removes the head packet only when bits [1:0] of the head's status equal `cmd_own`. It then returns `rsp_found`=1 and `rsp_idx` equal to the old head, and the new head is the next-link of the descriptor named by the old head's last field. Otherwise it returns `rsp_found`=0 and leaves the queue unchanged.
- R4: A mismatch-dequeue (op 3) removes the head packet only when its ownership bits differ from `cmd_own`. With `cmd_own`=0 (software), a head owned by hardware (1) is removed. With `cmd_own` equal to the head's code (2, special), nothing is removed.
- R5: Either dequeue on an empty queue returns `rsp_found`=0.
- R6: Append (op 4, first index `cmd_idx`, last index `cmd_idx2`) sets the new last descriptor's next-link to the terminator. If the queue was empty, the head becomes `cmd_idx`. If not, the previous tail's next-link becomes `cmd_idx`. Afterwards the queue is not empty.
- R7: Re-arm (op 5) sets status bits [1:0] of `cmd_idx` to 1 (hardware) and leaves status bits [15:2] and every other field unchanged.
- R8: Count (op 6) returns on `rsp_count` the number of descriptors reached by next-links from the head up to the terminator, sub-descriptors included. The result is 0 when the queue is empty and never exceeds the RAM depth.
- R9: Receive restore (op 7) sets the status of `cmd_idx` to 0x0001, its total length to 320 and its last field to `cmd_idx`. Control, data size and next-link are unchanged.
- R10: `cmd_ready` is low from the cycle after an accepted command until its response. Each accepted command gives exactly one single-cycle `rsp_valid` pulse.
- R11: `q_empty` is 1 exactly when the head equals the terminator index (parameter `TERM_IDX`, default 0). It returns to 1 after the last packet is dequeued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command request |
| cmd_ready | output | 1 | Block idle, command accepted on this cycle if valid |
| cmd_op | input | 3 | Command code (0 write, 1 read, 2 match-dequeue, 3 mismatch-dequeue, 4 append, 5 re-arm, 6 count, 7 receive restore) |
| cmd_idx | input | IW | Target descriptor, or first descriptor of an appended chain |
| cmd_idx2 | input | IW | Last descriptor of an appended chain |
| cmd_own | input | 2 | Ownership code compared by the dequeue commands |
| cmd_status | input | 16 | Status word for a write |
| cmd_ctrl | input | 16 | Control word for a write |
| cmd_dsize | input | 16 | Data size for a write |
| cmd_tlen | input | 16 | Total length for a write |
| cmd_last | input | IW | Last-descriptor index for a write |
| cmd_next | input | IW | Next-descriptor index for a write |
| rsp_valid | output | 1 | One-cycle response pulse |
| rsp_found | output | 1 | Dequeue removed a packet |
| rsp_idx | output | IW | First descriptor of the removed packet |
| rsp_count | output | CW | Descriptor count result |
| rsp_status | output | 16 | Read result: status |
| rsp_ctrl | output | 16 | Read result: control |
| rsp_dsize | output | 16 | Read result: data size |
| rsp_tlen | output | 16 | Read result: total length |
| rsp_last | output | IW | Read result: last-descriptor index |
| rsp_next | output | IW | Read result: next-descriptor index |
| q_empty | output | 1 | Head equals the terminator |

## Verification
The assertions assume that every chain handed to append is well formed:

- it is acyclic;
- following next-links from its first descriptor reaches its last descriptor;
- each packet's last field points inside that packet;
- it never includes the terminator or a descriptor already queued.

Under those conditions a dequeued head can never come back as the new head, and a count walk never revisits an entry. The directed stimulus builds only such chains: a three-descriptor packet and two single-descriptor packets with distinct indices. The bench keeps `cmd_valid` low until the previous response has arrived.

// File: rtl/dq_pkg.sv
package dq_pkg;

  typedef enum logic [2:0] {
    OP_WRITE  = 3'd0,
    OP_READ   = 3'd1,
    OP_DEQ_EQ = 3'd2,
    OP_DEQ_NE = 3'd3,
    OP_APPEND = 3'd4,
    OP_REARM  = 3'd5,
    OP_COUNT  = 3'd6,
    OP_RXINIT = 3'd7
  } dq_op_e;

  localparam logic [1:0] OWN_SW = 2'd0;
  localparam logic [1:0] OWN_HW = 2'd1;
  localparam logic [1:0] OWN_SP = 2'd2;

  localparam logic [15:0] RX_TOTAL_LEN = 16'd320;

  typedef struct packed {
    logic [15:0] status;
    logic [15:0] ctrl;
    logic [15:0] dsize;
    logic [15:0] tlen;
  } dq_hdr_t;

  localparam int HDR_W = $bits(dq_hdr_t);

endpackage

// File: rtl/dq_desc_ram.sv
module dq_desc_ram #(
  parameter int DEPTH = 32,
  parameter int AW    = 5,
  parameter int W     = 74
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [W-1:0]  wdata,
  output logic [W-1:0]  rdata
);

  logic [W-1:0] mem [DEPTH];

  // single port, read-first, registered read: maps onto block RAM
  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
    rdata <= mem[addr];
  end

endmodule

// File: rtl/dq_own_gate.sv
module dq_own_gate
  import dq_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] own,
  input  logic [1:0] want,
  input  logic       invert,
  output logic       take
);

  always_comb begin
    if (invert) take = (own != want);
    else        take = (own == want);
  end

  // a software request in mismatch mode must release a hardware-owned head
  p_sw_takes_hw_r4: assert property (@(posedge clk) disable iff (rst)
    (invert && want == OWN_SW && own == OWN_HW) |-> take);

  // match mode never takes a head whose code differs from the request
  p_match_only_equal_r3: assert property (@(posedge clk) disable iff (rst)
    (!invert && take) |-> (own == want));

endmodule

// File: rtl/dq_queue_mgr.sv
module dq_queue_mgr
  import dq_pkg::*;
#(
  parameter int DEPTH    = 32,
  parameter int IW       = $clog2(DEPTH),
  parameter int CW       = $clog2(DEPTH + 1),
  parameter int TERM_IDX = 0
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cmd_valid,
  output logic          cmd_ready,
  input  logic [2:0]    cmd_op,
  input  logic [IW-1:0] cmd_idx,
  input  logic [IW-1:0] cmd_idx2,
  input  logic [1:0]    cmd_own,
  input  logic [15:0]   cmd_status,
  input  logic [15:0]   cmd_ctrl,
  input  logic [15:0]   cmd_dsize,
  input  logic [15:0]   cmd_tlen,
  input  logic [IW-1:0] cmd_last,
  input  logic [IW-1:0] cmd_next,
  output logic          rsp_valid,
  output logic          rsp_found,
  output logic [IW-1:0] rsp_idx,
  output logic [CW-1:0] rsp_count,
  output logic [15:0]   rsp_status,
  output logic [15:0]   rsp_ctrl,
  output logic [15:0]   rsp_dsize,
  output logic [15:0]   rsp_tlen,
  output logic [IW-1:0] rsp_last,
  output logic [IW-1:0] rsp_next,
  output logic          q_empty
);

  localparam int W = HDR_W + 2 * IW;
  localparam logic [IW-1:0] TERM = IW'(TERM_IDX);
  localparam logic [CW-1:0] CMAX = CW'(DEPTH);

  typedef enum logic [4:0] {
    S_IDLE, S_FIN, S_WR, S_RD, S_RDD,
    S_DQ_H, S_DQ_HD, S_DQ_L, S_DQ_LD,
    S_AP_R, S_AP_RD, S_AP_T, S_AP_TD,
    S_RA_R, S_RA_W, S_RX_R, S_RX_W,
    S_CN, S_CND
  } st_e;

  st_e           state;
  dq_op_e        c_op;
  logic [IW-1:0] c_idx, c_idx2, c_last, c_next;
  logic [1:0]    c_own;
  dq_hdr_t       c_hdr;
  logic [IW-1:0] head, tail, walk, lastsave;
  logic [CW-1:0] cnt;

  logic          ram_we;
  logic [IW-1:0] ram_addr;
  logic [W-1:0]  ram_wdata, ram_rdata;
  dq_hdr_t       rd_hdr, hdr_mod;
  logic [IW-1:0] rd_last, rd_next;
  logic          take;
  logic          accept;

  assign cmd_ready = (state == S_IDLE);
  assign accept    = cmd_valid && cmd_ready;
  assign q_empty   = (head == TERM);

  assign rd_hdr  = ram_rdata[W-1 -: HDR_W];
  assign rd_last = ram_rdata[2*IW-1 -: IW];
  assign rd_next = ram_rdata[IW-1:0];

  dq_desc_ram #(.DEPTH(DEPTH), .AW(IW), .W(W)) u_ram (
    .clk   (clk),
    .we    (ram_we),
    .addr  (ram_addr),
    .wdata (ram_wdata),
    .rdata (ram_rdata)
  );

  dq_own_gate u_gate (
    .clk    (clk),
    .rst    (rst),
    .own    (rd_hdr.status[1:0]),
    .want   (c_own),
    .invert (c_op == OP_DEQ_NE),
    .take   (take)
  );

  // RAM port steering: one access per cycle, read-modify-write in two steps
  always_comb begin
    ram_we    = 1'b0;
    ram_addr  = c_idx;
    hdr_mod   = rd_hdr;
    ram_wdata = {rd_hdr, rd_last, rd_next};
    case (state)
      S_WR: begin
        ram_we    = 1'b1;
        ram_wdata = {c_hdr, c_last, c_next};
      end
      S_DQ_H:  ram_addr = walk;
      S_DQ_L:  ram_addr = lastsave;
      S_AP_R:  ram_addr = c_idx2;
      S_AP_RD: begin
        ram_we    = 1'b1;
        ram_addr  = c_idx2;
        ram_wdata = {rd_hdr, rd_last, TERM};
      end
      S_AP_T:  ram_addr = tail;
      S_AP_TD: begin
        ram_we    = 1'b1;
        ram_addr  = tail;
        ram_wdata = {rd_hdr, rd_last, c_idx};
      end
      S_RA_W: begin
        ram_we             = 1'b1;
        hdr_mod.status[1:0] = OWN_HW;
        ram_wdata          = {hdr_mod, rd_last, rd_next};
      end
      S_RX_W: begin
        ram_we         = 1'b1;
        hdr_mod.status = {14'd0, OWN_HW};
        hdr_mod.tlen   = RX_TOTAL_LEN;
        ram_wdata      = {hdr_mod, c_idx, rd_next};
      end
      S_CN:    ram_addr = walk;
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= S_IDLE;
      c_op       <= OP_WRITE;
      c_idx      <= '0;
      c_idx2     <= '0;
      c_last     <= '0;
      c_next     <= '0;
      c_own      <= OWN_SW;
      c_hdr      <= '0;
      head       <= TERM;
      tail       <= TERM;
      walk       <= TERM;
      lastsave   <= '0;
      cnt        <= '0;
      rsp_valid  <= 1'b0;
      rsp_found  <= 1'b0;
      rsp_idx    <= '0;
      rsp_count  <= '0;
      rsp_status <= '0;
      rsp_ctrl   <= '0;
      rsp_dsize  <= '0;
      rsp_tlen   <= '0;
      rsp_last   <= '0;
      rsp_next   <= '0;
    end else begin
      rsp_valid <= 1'b0;
      case (state)
        S_IDLE: if (accept) begin
          c_op      <= dq_op_e'(cmd_op);
          c_idx     <= cmd_idx;
          c_idx2    <= cmd_idx2;
          c_own     <= cmd_own;
          c_hdr     <= '{status: cmd_status, ctrl: cmd_ctrl,
                         dsize: cmd_dsize, tlen: cmd_tlen};
          c_last    <= cmd_last;
          c_next    <= cmd_next;
          rsp_found <= 1'b0;
          walk      <= head;
          cnt       <= '0;
          case (dq_op_e'(cmd_op))
            OP_WRITE:  state <= S_WR;
            OP_READ:   state <= S_RD;
            OP_DEQ_EQ,
            OP_DEQ_NE: state <= (head == TERM) ? S_FIN : S_DQ_H;
            OP_APPEND: state <= S_AP_R;
            OP_REARM:  state <= S_RA_R;
            OP_COUNT:  state <= S_CN;
            default:   state <= S_RX_R;
          endcase
        end
        S_FIN: begin
          rsp_valid <= 1'b1;
          state     <= S_IDLE;
        end
        S_WR: begin
          rsp_valid <= 1'b1;
          state     <= S_IDLE;
        end
        S_RD:  state <= S_RDD;
        S_RDD: begin
          rsp_status <= rd_hdr.status;
          rsp_ctrl   <= rd_hdr.ctrl;
          rsp_dsize  <= rd_hdr.dsize;
          rsp_tlen   <= rd_hdr.tlen;
          rsp_last   <= rd_last;
          rsp_next   <= rd_next;
          rsp_valid  <= 1'b1;
          state      <= S_IDLE;
        end
        S_DQ_H:  state <= S_DQ_HD;
        S_DQ_HD: begin
          if (take) begin
            lastsave <= rd_last;
            state    <= S_DQ_L;
          end else begin
            rsp_valid <= 1'b1;
            state     <= S_IDLE;
          end
        end
        S_DQ_L:  state <= S_DQ_LD;
        S_DQ_LD: begin
          head      <= rd_next;
          rsp_found <= 1'b1;
          rsp_idx   <= walk;
          rsp_valid <= 1'b1;
          state     <= S_IDLE;
        end
        S_AP_R:  state <= S_AP_RD;
        S_AP_RD: begin
          if (head == TERM) begin
            head      <= c_idx;
            tail      <= c_idx2;
            rsp_valid <= 1'b1;
            state     <= S_IDLE;
          end else begin
            state <= S_AP_T;
          end
        end
        S_AP_T:  state <= S_AP_TD;
        S_AP_TD: begin
          tail      <= c_idx2;
          rsp_valid <= 1'b1;
          state     <= S_IDLE;
        end
        S_RA_R: state <= S_RA_W;
        S_RX_R: state <= S_RX_W;
        S_RA_W, S_RX_W: begin
          rsp_valid <= 1'b1;
          state     <= S_IDLE;
        end
        S_CN: begin
          if (walk == TERM || cnt == CMAX) begin
            rsp_count <= cnt;
            rsp_valid <= 1'b1;
            state     <= S_IDLE;
          end else begin
            state <= S_CND;
          end
        end
        S_CND: begin
          cnt   <= cnt + 1'b1;
          walk  <= rd_next;
          state <= S_CN;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  // ---------------- assertions ----------------
  logic pend;
  always_ff @(posedge clk) begin
    if (rst) pend <= 1'b0;
    else if (accept) pend <= 1'b1;
    else if (rsp_valid) pend <= 1'b0;
  end

  p_busy_after_accept_r10: assert property (@(posedge clk) disable iff (rst)
    accept |=> !cmd_ready);

  p_rsp_single_pulse_r10: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |=> !rsp_valid);

  p_rsp_owed_r10: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> pend);

  p_empty_deq_none_r5: assert property (@(posedge clk) disable iff (rst)
    (accept && (cmd_op == OP_DEQ_EQ || cmd_op == OP_DEQ_NE) && q_empty)
      |-> ##2 (rsp_valid && !rsp_found));

  p_append_fills_r6: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && c_op == OP_APPEND) |-> !q_empty);

  p_count_cap_r8: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> (rsp_count <= CMAX));

  p_found_head_moves_r3: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_found) |-> (head != rsp_idx));

endmodule

// File: tb/tb_dq_queue_mgr.sv
module tb_dq_queue_mgr;

  localparam int DEPTH = 32;
  localparam int IW    = 5;
  localparam int CW    = 6;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          cmd_valid = 1'b0;
  logic          cmd_ready;
  logic [2:0]    cmd_op = '0;
  logic [IW-1:0] cmd_idx = '0, cmd_idx2 = '0, cmd_last = '0, cmd_next = '0;
  logic [1:0]    cmd_own = '0;
  logic [15:0]   cmd_status = '0, cmd_ctrl = '0, cmd_dsize = '0, cmd_tlen = '0;
  logic          rsp_valid, rsp_found, q_empty;
  logic [IW-1:0] rsp_idx, rsp_last, rsp_next;
  logic [CW-1:0] rsp_count;
  logic [15:0]   rsp_status, rsp_ctrl, rsp_dsize, rsp_tlen;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  dq_queue_mgr #(.DEPTH(DEPTH), .IW(IW), .CW(CW), .TERM_IDX(0)) dut (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .cmd_idx(cmd_idx), .cmd_idx2(cmd_idx2), .cmd_own(cmd_own),
    .cmd_status(cmd_status), .cmd_ctrl(cmd_ctrl), .cmd_dsize(cmd_dsize),
    .cmd_tlen(cmd_tlen), .cmd_last(cmd_last), .cmd_next(cmd_next),
    .rsp_valid(rsp_valid), .rsp_found(rsp_found), .rsp_idx(rsp_idx),
    .rsp_count(rsp_count), .rsp_status(rsp_status), .rsp_ctrl(rsp_ctrl),
    .rsp_dsize(rsp_dsize), .rsp_tlen(rsp_tlen), .rsp_last(rsp_last),
    .rsp_next(rsp_next), .q_empty(q_empty)
  );

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic issue(input int op, input int idx, input int idx2, input int own,
                       input int st, input int ct, input int ds, input int tl,
                       input int la, input int nx);
    int wait_cnt;
    @(negedge clk);
    cmd_op = 3'(op); cmd_idx = IW'(idx); cmd_idx2 = IW'(idx2); cmd_own = 2'(own);
    cmd_status = 16'(st); cmd_ctrl = 16'(ct); cmd_dsize = 16'(ds); cmd_tlen = 16'(tl);
    cmd_last = IW'(la); cmd_next = IW'(nx);
    cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
    chk("R10 busy after accept", int'(cmd_ready), 0);
    wait_cnt = 0;
    while (!rsp_valid && wait_cnt < 200) begin
      @(negedge clk);
      wait_cnt++;
    end
    chk("R10 response arrives", int'(rsp_valid), 1);
  endtask

  task automatic wr(input int idx, input int st, input int ct, input int ds,
                    input int tl, input int la, input int nx);
    issue(0, idx, 0, 0, st, ct, ds, tl, la, nx);
  endtask

  task automatic rd(input int idx);
    issue(1, idx, 0, 0, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic count_is(input string req, input int exp);
    issue(6, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    chk(req, int'(rsp_count), exp);
  endtask

  task automatic t_reset();
    chk("R1 empty after reset", int'(q_empty), 1);
    chk("R1 ready after reset", int'(cmd_ready), 1);
    chk("R1 no response after reset", int'(rsp_valid), 0);
  endtask

  task automatic t_write_read();
    wr(5, 16'h8A02, 16'h0300, 16'd123, 16'd456, 9, 17);
    rd(5);
    chk("R2 status", int'(rsp_status), 16'h8A02);
    chk("R2 ctrl", int'(rsp_ctrl), 16'h0300);
    chk("R2 dsize", int'(rsp_dsize), 123);
    chk("R2 tlen", int'(rsp_tlen), 456);
    chk("R2 last", int'(rsp_last), 9);
    chk("R2 next", int'(rsp_next), 17);
    @(negedge clk);
    chk("R10 single pulse", int'(rsp_valid), 0);
  endtask

  task automatic t_empty();
    issue(2, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    chk("R5 match on empty", int'(rsp_found), 0);
    issue(3, 0, 0, 1, 0, 0, 0, 0, 0, 0);
    chk("R5 mismatch on empty", int'(rsp_found), 0);
    count_is("R8 empty count", 0);
  endtask

  task automatic t_build();
    wr(1, 16'h0001, 16'h0200, 10, 30, 3, 2);
    wr(2, 16'h0001, 16'h0000, 10, 0, 3, 3);
    wr(3, 16'h0001, 16'h0100, 10, 0, 3, 4);
    wr(4, 16'h0000, 16'h0300, 8, 8, 4, 31);
    issue(4, 1, 4, 0, 0, 0, 0, 0, 0, 0);
    chk("R6 not empty after append", int'(q_empty), 0);
    rd(4);
    chk("R6 new tail links terminator", int'(rsp_next), 0);
    count_is("R8 four descriptors", 4);
  endtask

  task automatic t_dequeue_rules();
    issue(2, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    chk("R3 hw head kept by sw match", int'(rsp_found), 0);
    count_is("R3 queue unchanged", 4);
    issue(3, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    chk("R4 sw mismatch takes hw head", int'(rsp_found), 1);
    chk("R4 removed index", int'(rsp_idx), 1);
    count_is("R3 whole packet skipped", 1);
  endtask

  task automatic t_append_tail();
    wr(6, 16'h0002, 16'h0300, 4, 4, 6, 9);
    issue(4, 6, 6, 0, 0, 0, 0, 0, 0, 0);
    rd(4);
    chk("R6 old tail links new chain", int'(rsp_next), 6);
    rd(6);
    chk("R6 chain end links terminator", int'(rsp_next), 0);
    count_is("R8 two descriptors", 2);
    issue(2, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    chk("R3 sw match found", int'(rsp_found), 1);
    chk("R3 sw match index", int'(rsp_idx), 4);
    issue(3, 0, 0, 2, 0, 0, 0, 0, 0, 0);
    chk("R4 equal code not removed", int'(rsp_found), 0);
    count_is("R4 queue unchanged", 1);
    issue(2, 0, 0, 2, 0, 0, 0, 0, 0, 0);
    chk("R3 special match found", int'(rsp_found), 1);
    chk("R3 special match index", int'(rsp_idx), 6);
    chk("R11 empty after last packet", int'(q_empty), 1);
    count_is("R8 count after drain", 0);
  endtask

  task automatic t_rearm();
    wr(7, 16'hABCE, 16'h1234, 5, 6, 9, 10);
    issue(5, 7, 0, 0, 0, 0, 0, 0, 0, 0);
    rd(7);
    chk("R7 own set to hw", int'(rsp_status), 16'hABCD);
    chk("R7 ctrl kept", int'(rsp_ctrl), 16'h1234);
    chk("R7 last kept", int'(rsp_last), 9);
    chk("R7 next kept", int'(rsp_next), 10);
  endtask

  task automatic t_rxinit();
    wr(8, 16'h00F2, 16'h0301, 77, 5, 3, 11);
    issue(7, 8, 0, 0, 0, 0, 0, 0, 0, 0);
    rd(8);
    chk("R9 status", int'(rsp_status), 16'h0001);
    chk("R9 tlen", int'(rsp_tlen), 320);
    chk("R9 last self", int'(rsp_last), 8);
    chk("R9 ctrl kept", int'(rsp_ctrl), 16'h0301);
    chk("R9 dsize kept", int'(rsp_dsize), 77);
    chk("R9 next kept", int'(rsp_next), 11);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_write_read();
    t_empty();
    t_build();
    t_dequeue_rules();
    t_append_tail();
    t_rearm();
    t_rxinit();
    if (!done) begin
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      total++;
      bad++;
      $display("FAIL watchdog: actual=expired expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule